// File: doc/BRIEF.md
# Dual-Cache Snooping Coherence Controller

This block keeps one shared block of data coherent between two processor-side caches that sit on a common bus in front of one memory word. Each cache tracks a single block. Each line is in one of three states: Invalid, Shared or Modified. Each processor port takes read and write requests through a valid/ready handshake and returns read data one cycle later. A run-time policy input chooses the coherence scheme. In the invalidation scheme a writer claims the block and the other copy is dropped, and memory is updated only when the dirty copy is written back. In the update scheme every write is broadcast, so the other copy and memory are both refreshed.

All accesses pass through a fixed-priority arbiter, so only one transaction at a time can change coherence state. The monitor pins show, for every cycle, the bus transaction code, the port that drives it, the data it carries, and the current memory word.

Back-pressure rules: a request is taken on a clock edge where valid and ready are both high. Port 0 is never stalled. Port 1 sees ready low whenever port 0 is valid, unless both requests are read hits. A stalled port must hold its request stable until it is accepted. The read response has no ready: it is a one-cycle pulse that the processor must take.

Top module: `snoop_pair_ctrl`

## Requirements
- R1: After reset both lines are Invalid, memory holds 0, the bus code is 0, and the first read from either port is a read miss that returns 0.
- R2: A read to a Shared or Modified line returns the line's data with bus code 0 (none).
- R3: A read to an Invalid line drives bus code 1 (read miss). When the other cache is not Modified, memory supplies the data and the bus data pins carry it. The line becomes Shared.
- R4: On a read miss while the other cache holds the block Modified, that cache supplies the data and memory takes the same value at the same clock edge. The supplier drops to Shared, so its next write under the invalidation policy needs bus code 2.
- R5: Under the invalidation policy (policy input 0), a write to a Shared or Invalid line drives bus code 2 (invalidate) with the write data. The other copy becomes Invalid and the writer becomes Modified. Memory is unchanged unless the other copy was Modified, in which case that dirty data is written back.
- R6: Under the invalidation policy, a write to a Modified line produces bus code 0 and leaves memory unchanged.
- R7: Under the update policy (policy input 1), every write drives bus code 3 (broadcast). Memory and any valid copy in the other cache take the write data at that edge, and both copies end Shared.
- R8: When both ports are valid, port 0 is granted. Port 1 is held off with ready low, except when both requests are read hits, in which case both are served. The source pin shows the granted port (0 or 1) whenever the bus code is nonzero.
- R9: The policy input is sampled only on a cycle with neither request valid. A change presented while any request is valid has no effect on that or later transactions until an idle cycle.
- R10: A read accepted on an edge gives a one-cycle response pulse after that edge. A write gives no response.
- R11: Every read returns the data of the most recently accepted write anywhere in the system (0 before any write), so both ports observe one write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 1 | Requested policy: 0 invalidate, 1 update |
| policy_upd | output | 1 | Policy in force |
| p0_req_valid | input | 1 | Port 0 request valid |
| p0_req_ready | output | 1 | Port 0 request accepted |
| p0_req_write | input | 1 | Port 0 request is a write |
| p0_req_wdata | input | DW | Port 0 write data |
| p0_rsp_valid | output | 1 | Port 0 read data valid |
| p0_rsp_data | output | DW | Port 0 read data |
| p1_req_valid | input | 1 | Port 1 request valid |
| p1_req_ready | output | 1 | Port 1 request accepted |
| p1_req_write | input | 1 | Port 1 request is a write |
| p1_req_wdata | input | DW | Port 1 write data |
| p1_rsp_valid | output | 1 | Port 1 read data valid |
| p1_rsp_data | output | DW | Port 1 read data |
| bus_op | output | 2 | Bus code: 0 none, 1 read miss, 2 invalidate, 3 broadcast |
| bus_src | output | 1 | Port that owns the current transaction |
| bus_data | output | DW | Data carried by the current transaction |
| mem_word | output | DW | Memory contents |

## Verification
The bench first replays the classic two-processor sequence under both policies. This separates the write-back behaviour (memory stays stale until a dirty copy is supplied) from the write-through behaviour (memory follows every write), and it separates the first invalidating write from later silent writes. Same-cycle pairs from both ports then show the difference between a write collision, where port 1 stalls, and two read hits, where both are served. Long seeded random runs mix reads, writes and policy toggles on both ports, and every result is compared with a bench model. A read returning anything other than the last accepted write would expose a serialization fault.

// File: rtl/snoop_pkg.sv
`timescale 1ns/1ps
package snoop_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BOP_NONE   = 2'd0,
    BOP_RDMISS = 2'd1,
    BOP_INVAL  = 2'd2,
    BOP_BCAST  = 2'd3
  } bus_op_e;

  localparam int NUM_CACHES = 2;
endpackage

// File: rtl/snoop_line.sv
`timescale 1ns/1ps
module snoop_line
  import snoop_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_mode,
  input  logic          acc_valid,
  input  logic          acc_go,
  input  logic          acc_wr,
  input  logic [DW-1:0] acc_wdata,
  input  logic [DW-1:0] fill_data,
  input  bus_op_e       snp_op,
  input  logic [DW-1:0] snp_data,
  output line_st_e      st_o,
  output logic [DW-1:0] data_o,
  output bus_op_e       req_op_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  line_st_e      st_q, st_d;
  logic [DW-1:0] data_q, data_d;
  logic          hit;

  assign hit = (st_q != LN_INV);

  // Transaction this request would need on the bus.
  always_comb begin
    req_op_o = BOP_NONE;
    if (acc_valid) begin
      if (!acc_wr)       req_op_o = hit ? BOP_NONE : BOP_RDMISS;
      else if (upd_mode) req_op_o = BOP_BCAST;
      else               req_op_o = (st_q == LN_MOD) ? BOP_NONE : BOP_INVAL;
    end
  end

  // Own access takes precedence; otherwise react to the other cache's transaction.
  always_comb begin
    st_d   = st_q;
    data_d = data_q;
    if (acc_go) begin
      if (!acc_wr) begin
        if (!hit) begin
          st_d   = LN_SHR;
          data_d = fill_data;
        end
      end else begin
        st_d   = upd_mode ? LN_SHR : LN_MOD;
        data_d = acc_wdata;
      end
    end else begin
      unique case (snp_op)
        BOP_RDMISS: if (st_q == LN_MOD) st_d = LN_SHR;
        BOP_INVAL:  st_d = LN_INV;
        BOP_BCAST:  if (hit) begin
                      st_d   = LN_SHR;
                      data_d = snp_data;
                    end
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= LN_INV;
      data_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      st_q        <= st_d;
      data_q      <= data_d;
      rsp_valid_o <= acc_go && !acc_wr;
      if (acc_go && !acc_wr) rsp_data_o <= hit ? data_q : fill_data;
    end
  end

  assign st_o   = st_q;
  assign data_o = data_q;
endmodule

// File: rtl/snoop_arb.sv
`timescale 1ns/1ps
module snoop_arb
  import snoop_pkg::*;
(
  input  logic [1:0] req_valid,
  input  logic [1:0] req_wr,
  input  bus_op_e    op0,
  input  bus_op_e    op1,
  output logic [1:0] grant,
  output logic       win,
  output bus_op_e    cyc_op
);
  logic both_hits;

  assign both_hits = !req_wr[0] && !req_wr[1] &&
                     (op0 == BOP_NONE) && (op1 == BOP_NONE);

  always_comb begin
    grant[0] = req_valid[0];
    grant[1] = req_valid[1] && (!req_valid[0] || both_hits);
    win      = !grant[0];
    if (grant[0])      cyc_op = op0;
    else if (grant[1]) cyc_op = op1;
    else               cyc_op = BOP_NONE;
  end
endmodule

// File: rtl/snoop_pair_ctrl.sv
`timescale 1ns/1ps
module snoop_pair_ctrl
  import snoop_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          policy_sel,
  output logic          policy_upd,
  input  logic          p0_req_valid,
  output logic          p0_req_ready,
  input  logic          p0_req_write,
  input  logic [DW-1:0] p0_req_wdata,
  output logic          p0_rsp_valid,
  output logic [DW-1:0] p0_rsp_data,
  input  logic          p1_req_valid,
  output logic          p1_req_ready,
  input  logic          p1_req_write,
  input  logic [DW-1:0] p1_req_wdata,
  output logic          p1_rsp_valid,
  output logic [DW-1:0] p1_rsp_data,
  output logic [1:0]    bus_op,
  output logic          bus_src,
  output logic [DW-1:0] bus_data,
  output logic [DW-1:0] mem_word
);
  localparam int NC = NUM_CACHES;

  logic [NC-1:0] vld, wr, go, rspv;
  logic [DW-1:0] wd   [NC];
  logic [DW-1:0] ld   [NC];
  logic [DW-1:0] fill [NC];
  logic [DW-1:0] snpd [NC];
  logic [DW-1:0] rspd [NC];
  bus_op_e       rop  [NC];
  bus_op_e       snp  [NC];
  line_st_e      st   [NC];
  logic          mode_q;
  logic [DW-1:0] mem_q;
  logic          win, loser;
  bus_op_e       cyc_op;

  assign vld   = {p1_req_valid, p0_req_valid};
  assign wr    = {p1_req_write, p0_req_write};
  assign wd[0] = p0_req_wdata;
  assign wd[1] = p1_req_wdata;

  snoop_arb u_arb (
    .req_valid (vld),
    .req_wr    (wr),
    .op0       (rop[0]),
    .op1       (rop[1]),
    .grant     (go),
    .win       (win),
    .cyc_op    (cyc_op)
  );

  genvar g;
  generate
    for (g = 0; g < NC; g++) begin : g_line
      localparam int OTH = NC - 1 - g;
      assign fill[g] = (st[OTH] == LN_MOD) ? ld[OTH] : mem_q;
      assign snp[g]  = go[OTH] ? rop[OTH] : BOP_NONE;
      assign snpd[g] = wd[OTH];

      snoop_line #(.DW(DW)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_mode    (mode_q),
        .acc_valid   (vld[g]),
        .acc_go      (go[g]),
        .acc_wr      (wr[g]),
        .acc_wdata   (wd[g]),
        .fill_data   (fill[g]),
        .snp_op      (snp[g]),
        .snp_data    (snpd[g]),
        .st_o        (st[g]),
        .data_o      (ld[g]),
        .req_op_o    (rop[g]),
        .rsp_valid_o (rspv[g]),
        .rsp_data_o  (rspd[g])
      );
    end
  endgenerate

  assign loser = ~win;

  // Memory: written through on broadcast, refreshed from a dirty copy otherwise.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      unique case (cyc_op)
        BOP_BCAST:            mem_q <= wd[win];
        BOP_RDMISS, BOP_INVAL: if (st[loser] == LN_MOD) mem_q <= ld[loser];
        default:              ;
      endcase
    end
  end

  // Policy is latched only while nothing is requesting.
  always_ff @(posedge clk) begin
    if (!rst_n)    mode_q <= 1'b0;
    else if (!(|vld)) mode_q <= policy_sel;
  end

  always_comb begin
    unique case (cyc_op)
      BOP_RDMISS:           bus_data = fill[win];
      BOP_INVAL, BOP_BCAST: bus_data = wd[win];
      default:              bus_data = '0;
    endcase
  end

  assign bus_op       = cyc_op;
  assign bus_src      = win;
  assign mem_word     = mem_q;
  assign policy_upd   = mode_q;
  assign p0_req_ready = go[0];
  assign p1_req_ready = go[1];
  assign p0_rsp_valid = rspv[0];
  assign p1_rsp_valid = rspv[1];
  assign p0_rsp_data  = rspd[0];
  assign p1_rsp_data  = rspd[1];
endmodule

// File: rtl/snoop_pair_ctrl_chk.sv
`timescale 1ns/1ps
module snoop_pair_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          policy_sel,
  input logic          policy_upd,
  input logic          p0_req_valid,
  input logic          p0_req_ready,
  input logic          p0_req_write,
  input logic [DW-1:0] p0_req_wdata,
  input logic          p0_rsp_valid,
  input logic [DW-1:0] p0_rsp_data,
  input logic          p1_req_valid,
  input logic          p1_req_ready,
  input logic          p1_req_write,
  input logic [DW-1:0] p1_req_wdata,
  input logic          p1_rsp_valid,
  input logic [DW-1:0] p1_rsp_data,
  input logic [1:0]    bus_op,
  input logic          bus_src,
  input logic [DW-1:0] bus_data,
  input logic [DW-1:0] mem_word
);
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req_valid && p0_req_ready && !p0_req_write) |=> p0_rsp_valid); // R10

  AST_NO_RSP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_req_valid && p1_req_ready && p1_req_write) |=> !p1_rsp_valid); // R10

  AST_BCAST_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 2'd3) |=> (mem_word == $past(bus_data))); // R7

  AST_NO_INVAL_IN_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    policy_upd |-> (bus_op != 2'd2)); // R7

  AST_POLICY_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req_valid || p1_req_valid) |=> $stable(policy_upd)); // R9

  AST_P1_STALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req_valid && p0_req_write && p1_req_valid) |-> !p1_req_ready); // R8

  AST_INVAL_MEM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 2'd0) |=> $stable(mem_word)); // R6
endmodule

bind snoop_pair_ctrl snoop_pair_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/snoop_pair_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_pair_ctrl_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          policy_sel = 1'b0;
  logic          policy_upd;
  logic          p0_req_valid = 1'b0, p0_req_write = 1'b0;
  logic [DW-1:0] p0_req_wdata = '0;
  logic          p0_req_ready, p0_rsp_valid;
  logic [DW-1:0] p0_rsp_data;
  logic          p1_req_valid = 1'b0, p1_req_write = 1'b0;
  logic [DW-1:0] p1_req_wdata = '0;
  logic          p1_req_ready, p1_rsp_valid;
  logic [DW-1:0] p1_rsp_data;
  logic [1:0]    bus_op;
  logic          bus_src;
  logic [DW-1:0] bus_data, mem_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model: 0 Invalid, 1 Shared, 2 Modified
  int mst [2];
  int mdat[2];
  int mmem, mmode, last_wr;

  always #2 clk = ~clk;

  snoop_pair_ctrl #(.DW(DW)) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int need_op(int i, bit w);
    if (!w) return (mst[i] == 0) ? 1 : 0;
    if (mmode == 1) return 3;
    return (mst[i] == 2) ? 0 : 2;
  endfunction

  function automatic string op_tag(int op);
    case (op)
      1: return "R3";
      2: return "R5";
      3: return "R7";
      default: return "R2";
    endcase
  endfunction

  // Applies one granted access to the model; returns data read or bus data.
  function automatic int apply(int i, bit w, int d);
    int j = 1 - i;
    int r;
    if (!w) begin
      if (mst[i] == 0) begin
        r = (mst[j] == 2) ? mdat[j] : mmem;
        if (mst[j] == 2) begin mmem = mdat[j]; mst[j] = 1; end
        mst[i] = 1; mdat[i] = r;
      end else r = mdat[i];
    end else if (mmode == 0) begin
      if (mst[i] != 2) begin
        if (mst[j] == 2) mmem = mdat[j];
        mst[j] = 0;
      end
      mst[i] = 2; mdat[i] = d; r = d; last_wr = d;
    end else begin
      if (mst[j] != 0) begin mdat[j] = d; mst[j] = 1; end
      mmem = d; mst[i] = 1; mdat[i] = d; r = d; last_wr = d;
    end
    return r;
  endfunction

  task automatic step(input bit v0, input bit w0, input int d0,
                      input bit v1, input bit w1, input int d1, input bit ps);
    bit g0, g1;
    int eop, esrc, edata, r0, r1, op1;
    @(negedge clk);
    p0_req_valid = v0; p0_req_write = w0; p0_req_wdata = d0[DW-1:0];
    p1_req_valid = v1; p1_req_write = w1; p1_req_wdata = d1[DW-1:0];
    policy_sel = ps;
    #1;
    eop = need_op(0, w0);
    op1 = need_op(1, w1);
    g0 = v0;
    g1 = v1 && (!v0 || (!w0 && !w1 && eop == 0 && op1 == 0));
    if (v0) chk("R8 p0 ready", p0_req_ready, 1);
    if (v1) chk("R8 p1 ready", p1_req_ready, g1);
    esrc = g0 ? 0 : 1;
    if (!g0) eop = g1 ? op1 : 0;
    r0 = 0; r1 = 0; edata = 0;
    if (g0) r0 = apply(0, w0, d0);
    if (g1) r1 = apply(1, w1, d1);
    edata = g0 ? r0 : r1;
    chk(op_tag(eop), bus_op, eop);
    if (eop != 0) begin
      chk("R8 source", bus_src, esrc);
      chk("R4 bus data", bus_data, edata);
    end
    @(posedge clk); #1;
    chk("R10 p0 rsp", p0_rsp_valid, g0 && !w0);
    chk("R10 p1 rsp", p1_rsp_valid, g1 && !w1);
    if (g0 && !w0) begin
      chk("R11 p0 data", p0_rsp_data, r0);
      chk("R11 p0 last write", p0_rsp_data, last_wr);
    end
    if (g1 && !w1) begin
      chk("R11 p1 data", p1_rsp_data, r1);
      chk("R11 p1 last write", p1_rsp_data, last_wr);
    end
    chk("R5 memory", mem_word, mmem);
    if (!v0 && !v1) mmode = ps;
    chk("R9 policy", policy_upd, mmode);
  endtask

  initial begin
    #(100000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C0DE5));
    mst = '{0, 0}; mdat = '{0, 0}; mmem = 0; mmode = 0; last_wr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 bus idle", bus_op, 0);
    chk("R1 memory zero", mem_word, 0);
    @(negedge clk); rst_n = 1'b1;

    // invalidation sequence (R1 R3 R5 R4 R6)
    step(1, 0, 0, 0, 0, 0, 0);   // A reads: miss, 0
    step(0, 0, 0, 1, 0, 0, 0);   // B reads: miss
    step(1, 1, 1, 0, 0, 0, 0);   // A writes 1: invalidate, memory stays 0
    chk("R5 memory stale", mem_word, 0);
    step(0, 0, 0, 1, 0, 0, 0);   // B reads: A supplies 1, memory 1
    chk("R4 memory refreshed", mem_word, 1);
    step(1, 1, 2, 0, 0, 0, 0);   // A was Shared: invalidate again
    step(1, 1, 3, 0, 0, 0, 0);   // A Modified: silent write R6
    // R9: policy change while busy is ignored
    step(1, 1, 4, 0, 0, 0, 1);
    chk("R9 policy held", policy_upd, 0);
    step(0, 0, 0, 0, 0, 0, 1);   // idle: switch to update
    chk("R9 policy taken", policy_upd, 1);
    step(0, 0, 0, 1, 0, 0, 1);   // B read miss, A dirty supplies 4
    step(1, 1, 5, 0, 0, 0, 1);   // broadcast R7
    step(0, 0, 0, 1, 0, 0, 1);   // B read hit returns 5 (R2)
    step(1, 0, 0, 1, 0, 0, 1);   // both read hits: both served R8
    step(1, 1, 6, 1, 1, 7, 1);   // collision: p1 stalls R8
    step(0, 0, 0, 1, 1, 7, 1);   // p1 proceeds
    step(0, 0, 0, 0, 0, 0, 0);

    for (int n = 0; n < 1500; n++) begin
      bit v0 = $urandom_range(1, 0);
      bit v1 = $urandom_range(1, 0);
      step(v0, $urandom_range(1, 0), $urandom_range(255, 0),
           v1, $urandom_range(1, 0), $urandom_range(255, 0),
           ($urandom_range(7, 0) == 0) ? ~mmode[0] : mmode[0]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule